// File: doc/BRIEF.md
# Section BIP-8 Parity Monitor and Inserter

This block handles the section parity byte (B1) of a byte-wide SONET/SDH stream that an upstream framer has already aligned. It sees both directions of a section terminator. On the receive side it takes every scrambled byte of a frame and folds it into an 8-bit even parity value. When the B1 byte of the next frame arrives in descrambled form, it compares that byte with the stored value and produces a per-bit error mask. As an option, it writes the locally computed parity over the received B1, so that equipment further down the line does not see the same errors again.

On the transmit side, the external scrambler returns its scrambled output to the block as a feedback stream. The block accumulates parity over that stream, frame by frame. It then places the result of frame k into the B1 byte of frame k+1 before that byte reaches the scrambler. A user mask is XORed onto the result to inject deliberate parity errors. An inhibit flag leaves the outgoing B1 untouched, and a global pass-through switch turns off every B1 change in both directions. The provisioned rate moves the B1 location. Frame boundaries come only from the start-of-frame markers.

Top module: `b1_parity_unit`

## Requirements
- R1: Receive parity of a frame is the XOR of all `rx_scr` bytes taken while `rx_valid` is high and `rx_oof` is low, from one `rx_sof` byte up to the byte before the next `rx_sof`. One cycle after the B1 byte of the following frame, `rx_mask` equals that parity XOR the `rx_dsc` value at B1, and `rx_mask_vld` is high.
- R2: B1 is the byte at index 90·N after the `rx_sof`/`tx_sof` byte (index 0). N is 1 for `rate_sel`=0, 3 for `rate_sel`=1, and 12 for `rate_sel`=2 or 3. No other byte index produces a mask or a substitution.
- R3: The first frame after reset, and the first frame after any cycle with `rx_oof` high, has no previous parity. For it `rx_mask` stays 00h and `rx_mask_vld` stays low. While `rx_oof` is high, `rx_mask_vld` stays low.
- R4: With `cfg_rx_fix`=1, the byte that `rx_out` shows for a B1 position that has a valid previous parity is the calculated parity, not the received byte.
- R5: On transmit, B1 of frame k+1 leaves on `tx_out` as (XOR of all `fb_scr` bytes of feedback frame k) XOR `cfg_tx_mask`. A mask of 00h gives the clean parity, and a mask with four bits set differs from it in exactly four bits.
- R6: With `cfg_tx_inhibit`=1, the transmit B1 byte leaves as it entered on `tx_in`.
- R7: With `cfg_passthru`=1, neither the receive substitution nor the transmit insertion takes place; the receive mask is still reported.
- R8: Every byte other than a modified B1 appears on `rx_out`/`tx_out` one cycle after it is presented, unchanged. `rx_out_vld`/`tx_out_vld` equal the previous cycle's `rx_valid`/`tx_valid`.
- R9: Until one full feedback frame (from one `fb_sof` up to the next) has been seen since reset, the transmit B1 passes through unchanged.
- R10: `rx_mask_vld` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Rate: 0 STS-1, 1 STS-3, 2/3 STS-12 |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | Receive byte is the first of a frame |
| rx_oof | input | 1 | Receive out of frame; clears parity history |
| rx_scr | input | 8 | Receive byte before descrambling |
| rx_dsc | input | 8 | Same receive byte after descrambling |
| cfg_rx_fix | input | 1 | Substitute calculated parity into receive B1 |
| rx_out | output | 8 | Receive byte stream out |
| rx_out_vld | output | 1 | Receive output valid |
| rx_mask | output | 8 | Receive B1 error mask |
| rx_mask_vld | output | 1 | Error mask strobe |
| tx_valid | input | 1 | Transmit byte present |
| tx_sof | input | 1 | Transmit byte is the first of a frame |
| tx_in | input | 8 | Transmit byte before scrambling |
| fb_valid | input | 1 | Feedback byte present |
| fb_sof | input | 1 | Feedback byte is the first of a frame |
| fb_scr | input | 8 | Scrambled transmit byte fed back |
| cfg_tx_mask | input | 8 | Error-injection XOR mask for transmit B1 |
| cfg_tx_inhibit | input | 1 | Leave transmit B1 unmodified |
| cfg_passthru | input | 1 | Disable all B1 modification |
| tx_out | output | 8 | Transmit byte stream out |
| tx_out_vld | output | 1 | Transmit output valid |

## Verification
Each result is registered once, so `rx_out`, `rx_mask`, `rx_mask_vld` and `tx_out` for a byte are due in the cycle after the clock edge that takes that byte. The bench drives a byte on the falling edge, waits for the next rising edge and samples one time unit later, so each check reads the result for exactly the byte just driven. Expected parity is built in the bench from the bytes it sent. The mask and substitution checks therefore land on the byte at index 90·N, while every other index is checked for plain, unchanged passage.

// File: rtl/b1pm_pkg.sv
package b1pm_pkg;
  typedef enum logic [1:0] {
    RATE_STS1  = 2'd0,
    RATE_STS3  = 2'd1,
    RATE_STS12 = 2'd2,
    RATE_RSVD  = 2'd3
  } rate_e;

  // STS multiple selected by the rate code
  function automatic int unsigned sts_mult(rate_e r);
    case (r)
      RATE_STS1: return 1;
      RATE_STS3: return 3;
      default:   return 12;
    endcase
  endfunction

  // byte index of B1 counted from the frame-start byte
  function automatic int unsigned b1_index(rate_e r, int unsigned row_bytes);
    return row_bytes * sts_mult(r);
  endfunction
endpackage

// File: rtl/b1_frame_pos.sv
module b1_frame_pos #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             sof,
  input  logic [POS_W-1:0] offset,
  output logic             b1_hit
);
  localparam logic [POS_W-1:0] SAT = '1;

  logic [POS_W-1:0] pos;
  logic             framed;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos    <= '0;
      framed <= 1'b0;
    end else if (en) begin
      if (sof) begin
        pos    <= POS_W'(1);
        framed <= 1'b1;
      end else if (pos != SAT) begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  assign b1_hit = en && !sof && framed && (pos == offset);
endmodule

// File: rtl/b1_bip_acc.sv
module b1_bip_acc #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          sof,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] par_q,
  output logic          par_ok
);
  logic [DW-1:0] acc;
  logic          started;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc     <= '0;
      par_q   <= '0;
      par_ok  <= 1'b0;
      started <= 1'b0;
    end else if (en) begin
      if (sof) begin
        par_q   <= acc;
        par_ok  <= started;
        started <= 1'b1;
        acc     <= din;
      end else begin
        acc <= acc ^ din;
      end
    end
  end
endmodule

// File: rtl/b1_parity_unit.sv
module b1_parity_unit
  import b1pm_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ROW_BYTES = 90,
  parameter int MAX_STS   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    rate_sel,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_oof,
  input  logic [DW-1:0] rx_scr,
  input  logic [DW-1:0] rx_dsc,
  input  logic          cfg_rx_fix,
  output logic [DW-1:0] rx_out,
  output logic          rx_out_vld,
  output logic [DW-1:0] rx_mask,
  output logic          rx_mask_vld,
  input  logic          tx_valid,
  input  logic          tx_sof,
  input  logic [DW-1:0] tx_in,
  input  logic          fb_valid,
  input  logic          fb_sof,
  input  logic [DW-1:0] fb_scr,
  input  logic [DW-1:0] cfg_tx_mask,
  input  logic          cfg_tx_inhibit,
  input  logic          cfg_passthru,
  output logic [DW-1:0] tx_out,
  output logic          tx_out_vld
);
  localparam int POS_W = $clog2(ROW_BYTES * MAX_STS + 2);

  logic [POS_W-1:0] b1_off;
  assign b1_off = POS_W'(b1_index(rate_e'(rate_sel), ROW_BYTES));

  // receive side
  logic          rx_en, rx_hit, rx_ok;
  logic [DW-1:0] rx_par;
  assign rx_en = rx_valid && !rx_oof;

  b1_frame_pos #(.POS_W(POS_W)) u_rx_pos (
    .clk(clk), .rst(rst), .clr(rx_oof), .en(rx_en), .sof(rx_sof),
    .offset(b1_off), .b1_hit(rx_hit)
  );

  b1_bip_acc #(.DW(DW)) u_rx_acc (
    .clk(clk), .rst(rst), .clr(rx_oof), .en(rx_en), .sof(rx_sof),
    .din(rx_scr), .par_q(rx_par), .par_ok(rx_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_out      <= '0;
      rx_out_vld  <= 1'b0;
      rx_mask     <= '0;
      rx_mask_vld <= 1'b0;
    end else begin
      rx_out_vld  <= rx_valid;
      rx_mask_vld <= rx_hit && rx_ok;
      rx_mask     <= (rx_hit && rx_ok) ? (rx_par ^ rx_dsc) : '0;
      if (rx_hit && rx_ok && cfg_rx_fix && !cfg_passthru)
        rx_out <= rx_par;
      else
        rx_out <= rx_dsc;
    end
  end

  // transmit side
  logic          tx_hit, fb_ok;
  logic [DW-1:0] fb_par;

  b1_frame_pos #(.POS_W(POS_W)) u_tx_pos (
    .clk(clk), .rst(rst), .clr(1'b0), .en(tx_valid), .sof(tx_sof),
    .offset(b1_off), .b1_hit(tx_hit)
  );

  b1_bip_acc #(.DW(DW)) u_fb_acc (
    .clk(clk), .rst(rst), .clr(1'b0), .en(fb_valid), .sof(fb_sof),
    .din(fb_scr), .par_q(fb_par), .par_ok(fb_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out     <= '0;
      tx_out_vld <= 1'b0;
    end else begin
      tx_out_vld <= tx_valid;
      if (tx_hit && fb_ok && !cfg_passthru && !cfg_tx_inhibit)
        tx_out <= fb_par ^ cfg_tx_mask;
      else
        tx_out <= tx_in;
    end
  end
endmodule

// File: rtl/b1_parity_unit_chk.sv
module b1_parity_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_oof,
  input logic [DW-1:0] rx_dsc,
  input logic          cfg_rx_fix,
  input logic          cfg_passthru,
  input logic [DW-1:0] rx_out,
  input logic          rx_out_vld,
  input logic [DW-1:0] rx_mask,
  input logic          rx_mask_vld,
  input logic          tx_valid,
  input logic [DW-1:0] tx_in,
  input logic          cfg_tx_inhibit,
  input logic [DW-1:0] tx_out,
  input logic          tx_out_vld
);
  a_r3_no_mask_while_oof: assert property (@(posedge clk) disable iff (rst)
    rx_oof |=> !rx_mask_vld);

  a_r3_mask_zero_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !rx_mask_vld |-> (rx_mask == '0));

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rx_mask_vld |=> !rx_mask_vld);

  a_r8_rx_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rx_out_vld == $past(rx_valid)));

  a_r8_tx_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_out_vld == $past(tx_valid)));

  a_r7_rx_unchanged_without_fix: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (!cfg_rx_fix || cfg_passthru)) |=> (rx_out == $past(rx_dsc)));

  a_r6_tx_unchanged_when_blocked: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && (cfg_tx_inhibit || cfg_passthru)) |=> (tx_out == $past(tx_in)));
endmodule

bind b1_parity_unit b1_parity_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_oof(rx_oof), .rx_dsc(rx_dsc),
  .cfg_rx_fix(cfg_rx_fix), .cfg_passthru(cfg_passthru), .rx_out(rx_out),
  .rx_out_vld(rx_out_vld), .rx_mask(rx_mask), .rx_mask_vld(rx_mask_vld),
  .tx_valid(tx_valid), .tx_in(tx_in), .cfg_tx_inhibit(cfg_tx_inhibit),
  .tx_out(tx_out), .tx_out_vld(tx_out_vld)
);

// File: tb/b1_parity_unit_tb.sv
`timescale 1ns/1ps
module b1_parity_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] rate_sel;
  logic       rx_valid, rx_sof, rx_oof, cfg_rx_fix;
  logic [7:0] rx_scr, rx_dsc, rx_out, rx_mask;
  logic       rx_out_vld, rx_mask_vld;
  logic       tx_valid, tx_sof, fb_valid, fb_sof, cfg_tx_inhibit, cfg_passthru;
  logic [7:0] tx_in, fb_scr, cfg_tx_mask, tx_out;
  logic       tx_out_vld;

  int checks = 0;
  int failures = 0;
  logic [7:0] rx_prev = 8'h00;
  bit         rx_prev_ok = 1'b0;
  logic [7:0] tx_prev = 8'h00;
  bit         tx_prev_ok = 1'b0;

  always #2 clk = ~clk;

  b1_parity_unit u_dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_oof(rx_oof), .rx_scr(rx_scr),
    .rx_dsc(rx_dsc), .cfg_rx_fix(cfg_rx_fix), .rx_out(rx_out),
    .rx_out_vld(rx_out_vld), .rx_mask(rx_mask), .rx_mask_vld(rx_mask_vld),
    .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_in(tx_in),
    .fb_valid(fb_valid), .fb_sof(fb_sof), .fb_scr(fb_scr),
    .cfg_tx_mask(cfg_tx_mask), .cfg_tx_inhibit(cfg_tx_inhibit),
    .cfg_passthru(cfg_passthru), .tx_out(tx_out), .tx_out_vld(tx_out_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int i, input int seed);
    return 8'((i * 37 + seed * 11) ^ (i >> 5));
  endfunction

  task automatic idle();
    rx_valid = 0; rx_sof = 0; rx_oof = 0; rx_scr = 0; rx_dsc = 0;
    tx_valid = 0; tx_sof = 0; tx_in = 0; fb_valid = 0; fb_sof = 0; fb_scr = 0;
  endtask

  // one receive frame; b1 carries the previous parity XOR err
  task automatic rx_frame(input int nsts, input logic [7:0] err, input int seed, input string req);
    int off = 90 * nsts;
    int flen = 810 * nsts;
    logic [7:0] par = 8'h00;
    logic [7:0] exp_out;
    int bad = 0;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_scr = gen(i, seed);
      rx_dsc = (i == off) ? (rx_prev ^ err) : (gen(i, seed) ^ 8'h5A);
      par ^= rx_scr;
      @(posedge clk); #1;
      if (i == off) begin
        chk(rx_mask_vld == rx_prev_ok, {req, " mask strobe"}, rx_mask_vld, rx_prev_ok);
        chk(rx_mask == (rx_prev_ok ? err : 8'h00), {req, " mask value"}, rx_mask,
            rx_prev_ok ? err : 8'h00);
        exp_out = (cfg_rx_fix && !cfg_passthru && rx_prev_ok) ? rx_prev : rx_dsc;
        chk(rx_out == exp_out, {req, " B1 out"}, rx_out, exp_out);
      end else if (rx_out != rx_dsc || rx_mask_vld || !rx_out_vld) begin
        bad++;
      end
    end
    chk(bad == 0, "R8 R2 other bytes unchanged", bad, 0);
    @(negedge clk); idle();
    rx_prev = par; rx_prev_ok = 1'b1;
  endtask

  task automatic rx_oof_burst(input int len);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_oof = 1; rx_valid = 1; rx_sof = (i % 97 == 0); rx_scr = gen(i, 9); rx_dsc = gen(i, 4);
      @(posedge clk); #1;
      if (rx_mask_vld) bad++;
    end
    @(negedge clk); idle();
    chk(bad == 0, "R3 no strobe while out of frame", bad, 0);
    rx_prev_ok = 1'b0;
  endtask

  // one transmit frame with matching feedback frame
  task automatic tx_frame(input int seed, input string req, input bit four_bits);
    int off = 90;
    logic [7:0] par = 8'h00;
    logic [7:0] exp_out;
    int bad = 0;
    for (int i = 0; i < 810; i++) begin
      @(negedge clk);
      tx_valid = 1; tx_sof = (i == 0); tx_in = gen(i, seed) ^ 8'hC3;
      fb_valid = 1; fb_sof = (i == 0); fb_scr = gen(i, seed + 3);
      par ^= fb_scr;
      @(posedge clk); #1;
      if (i == off) begin
        exp_out = (!cfg_passthru && !cfg_tx_inhibit && tx_prev_ok) ? (tx_prev ^ cfg_tx_mask) : tx_in;
        chk(tx_out == exp_out, {req, " transmit B1"}, tx_out, exp_out);
        if (four_bits)
          chk($countones(tx_out ^ tx_prev) == 4, "R5 four injected errors",
              $countones(tx_out ^ tx_prev), 4);
      end else if (tx_out != tx_in || !tx_out_vld) begin
        bad++;
      end
    end
    chk(bad == 0, "R8 transmit other bytes unchanged", bad, 0);
    @(negedge clk); idle();
    tx_prev = par; tx_prev_ok = 1'b1;
  endtask

  task automatic test_reset();
    rst = 1; rate_sel = 2'd0; cfg_rx_fix = 0; cfg_tx_mask = 0; cfg_tx_inhibit = 0; cfg_passthru = 0;
    idle();
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk(rx_out == 0 && rx_mask == 0 && !rx_mask_vld && !rx_out_vld && tx_out == 0 && !tx_out_vld,
        "R3 reset state", {rx_mask_vld, rx_out_vld, tx_out_vld}, 0);
  endtask

  task automatic test_rx_basic();
    rx_frame(1, 8'h00, 1, "R3 first frame");
    rx_frame(1, 8'h00, 2, "R1 clean parity");
    rx_frame(1, 8'h13, 3, "R1 three errors");
  endtask

  task automatic test_rx_fix();
    cfg_rx_fix = 1;
    rx_frame(1, 8'h81, 4, "R4 substitution");
    cfg_passthru = 1;
    rx_frame(1, 8'h0F, 5, "R7 pass-through receive");
    cfg_passthru = 0; cfg_rx_fix = 0;
  endtask

  task automatic test_rx_oof();
    rx_oof_burst(300);
    rx_frame(1, 8'h55, 6, "R3 first frame after loss");
    rx_frame(1, 8'h40, 7, "R1 after reacquire");
  endtask

  task automatic test_rates();
    rate_sel = 2'd1; cfg_rx_fix = 1;
    rx_oof_burst(50);
    rx_frame(3, 8'h00, 8, "R2 STS-3 first");
    rx_frame(3, 8'h22, 9, "R2 STS-3 offset 270");
    rate_sel = 2'd2; cfg_rx_fix = 0;
    rx_oof_burst(50);
    rx_frame(12, 8'h00, 10, "R2 STS-12 first");
    rx_frame(12, 8'h99, 11, "R2 STS-12 offset 1080");
    rate_sel = 2'd0;
  endtask

  task automatic test_tx();
    cfg_tx_mask = 8'h00;
    tx_frame(20, "R9 no history", 0);
    tx_frame(21, "R5 clean insert", 0);
    cfg_tx_mask = 8'hB2;
    tx_frame(22, "R5 injected mask", 1);
    cfg_tx_inhibit = 1;
    tx_frame(23, "R6 inhibit", 0);
    cfg_tx_inhibit = 0; cfg_passthru = 1;
    tx_frame(24, "R7 pass-through transmit", 0);
    cfg_passthru = 0; cfg_tx_mask = 8'h00;
    tx_frame(25, "R5 clean after pass-through", 0);
  endtask

  initial begin
    test_reset();
    test_rx_basic();
    test_rx_fix();
    test_rx_oof();
    test_rates();
    test_tx();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule